// File: doc/BRIEF.md
# NAND Flash Host Register Front End

This block sits between a simple register bus and the pins of a raw 8-bit NAND flash device. Software writes command bytes, address bytes, write data and read requests into a small queue of pending bus cycles. A sequencer drains that queue strictly in order. Each command entry becomes a write strobe with CLE high. Each address entry becomes a write strobe with ALE high. Each data entry becomes a plain write strobe. Each read request becomes a read strobe.

A read takes two steps. Software first writes any value to the read-request register. Once the byte has been captured from the flash, a ready flag sets in the interrupt status register and software collects the byte from the read-data register. The sequencer also reports bus conditions through a status register, sticky event flags and a masked interrupt line. A control register holds the strobe widths and the page and bus-width settings. A self-clearing register restarts the external ECC generators.

Every byte written to or read from the flash array is also sent on a valid/ready stream to an ECC generator. The beat starts once the strobe has finished. It stays up with a stable byte until the consumer raises ready. While the beat waits, the sequencer does not start the next queued cycle. Back-pressure from the ECC side therefore stalls the flash bus, and data is never dropped. Register reads are combinational from `reg_addr`. Register writes take effect on the clock edge where `reg_wr` is high.

Top module: `nand_host_if`

## Requirements
- R1: CTRL (offset 0x0) resets to 0 and reads back exactly as written in bits 9:0. The fields are: write strobe width code in bits 3:0, read strobe width code in bits 7:4, bus width flag in bit 8, and 512-byte page flag in bit 9.
- R2: Writes to CMD (0x4), ADDR (0x5) and WDATA (0x6) produce flash write cycles in the order written. A CMD cycle has CLE high, an ADDR cycle has ALE high, a WDATA cycle has neither. Each cycle drives the written byte on `fl_dout`.
- R3: `fl_we_n` stays low for (CTRL[3:0] + 1) clock cycles on each write cycle. `fl_re_n` stays low for (CTRL[7:4] + 1) cycles on each read cycle.
- R4: A write of any value to RDREQ (0x7) queues one read cycle. The byte on `fl_din` in the last low cycle of `fl_re_n` is stored in RDDATA (0x8), and ISTAT bit 3 sets.
- R5: Writing ISTAT (0x2) clears each bit written as 1. An event in the same cycle wins over the clear.
- R6: The queue holds DEPTH entries, and STAT bit 1 is high while it is full. A queueing write while the queue is full is discarded, and ISTAT bit 1 sets.
- R7: STAT (0x1) shows the following. Bit 0 equals `fl_rdy`. Bit 2 is high while a data write cycle is in flight. Bit 3 is high while a requested read byte has not yet been captured. Bit 4 is high when the queue is empty and no cycle is in flight.
- R8: A rising edge on `fl_rdy` sets ISTAT bit 0.
- R9: Writing 1 to bit 0 of ECCRST (0x9) makes that bit read 1 and drives `ecc_clr` high for exactly ECC_RST_CYCLES cycles, after which both return to 0.
- R10: Write-data and read bytes appear as one beat each on `ecc_valid`/`ecc_data`. The beat holds with stable data until `ecc_ready`, and no further flash cycle starts before it is accepted.
- R11: ISTAT bit 2 sets when STAT bit 4 rises. ISTAT bit 4 sets when a data write cycle completes.
- R12: `irq` is high exactly when some ISTAT bit is set whose bit in IMASK (0x3) is also set.
- R13: CLE and ALE are never both high, and `fl_we_n` and `fl_re_n` are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt request |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_re_n | output | 1 | Flash read strobe, active low |
| fl_doe | output | 1 | Drive enable for fl_dout |
| fl_dout | output | 8 | Byte driven to flash |
| fl_din | input | 8 | Byte returned by flash |
| fl_rdy | input | 1 | Flash ready/busy, high = ready |
| ecc_valid | output | 1 | ECC stream beat valid |
| ecc_ready | input | 1 | ECC stream consumer ready |
| ecc_data | output | 8 | ECC stream byte |
| ecc_clr | output | 1 | ECC generator restart |

## Verification
Several properties are checked on every cycle. The pin exclusions are one. The ECC beat must hold while it is stalled. A dropped write must leave the queue count unchanged. The read-ready flag must follow a capture, the rising-ready event must be recorded, and the ECC restart must end when its countdown does. Other behaviour shows only in the bench's scenarios. These are the order and type of flash cycles against the register writes, the exact strobe widths for several width codes, and the captured read byte. They also include the overflow point at which the queue fills, the stall of later cycles under ECC back-pressure, write-1-to-clear, and interrupt masking.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;
  localparam int IST_W  = 5;

  typedef enum logic [1:0] {OP_CMD = 2'd0, OP_ADDR = 2'd1, OP_WDATA = 2'd2, OP_READ = 2'd3} op_e;

  typedef struct packed {
    op_e              op;
    logic [BYTE_W-1:0] byte_v;
  } wb_entry_t;

  localparam logic [3:0] RA_CTRL   = 4'h0;
  localparam logic [3:0] RA_STAT   = 4'h1;
  localparam logic [3:0] RA_ISTAT  = 4'h2;
  localparam logic [3:0] RA_IMASK  = 4'h3;
  localparam logic [3:0] RA_CMD    = 4'h4;
  localparam logic [3:0] RA_ADDR   = 4'h5;
  localparam logic [3:0] RA_WDATA  = 4'h6;
  localparam logic [3:0] RA_RDREQ  = 4'h7;
  localparam logic [3:0] RA_RDDATA = 4'h8;
  localparam logic [3:0] RA_ECCRST = 4'h9;

  localparam int IB_NBUSY = 0;
  localparam int IB_OVF   = 1;
  localparam int IB_EDGE  = 2;
  localparam int IB_RDRDY = 3;
  localparam int IB_WDONE = 4;
endpackage

// File: rtl/nand_wbuf.sv
module nand_wbuf
  import nand_host_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t push_entry,
  input  logic      pop,
  output wb_entry_t head,
  output logic      full,
  output logic      empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  wb_entry_t        mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[i] <= '0;
      else if (do_push && wr_ptr == PW'(i))  mem[i] <= push_entry;
    end
  end

  // R6
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));
endmodule

// File: rtl/nand_pin_seq.sv
module nand_pin_seq
  import nand_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wb_entry_t         head,
  input  logic              empty,
  output logic              pop,
  input  logic [3:0]        wr_dly,
  input  logic [3:0]        rd_dly,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_we_n,
  output logic              fl_re_n,
  output logic              fl_doe,
  output logic [BYTE_W-1:0] fl_dout,
  input  logic [BYTE_W-1:0] fl_din,
  output logic              ecc_valid,
  input  logic              ecc_ready,
  output logic [BYTE_W-1:0] ecc_data,
  output logic              rd_done,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              wr_done,
  output logic              idle,
  output logic              wr_busy
);
  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_HOLD} st_e;

  st_e       state;
  wb_entry_t cur;
  logic [3:0] cnt;
  logic      is_rd, has_ecc, active;

  assign is_rd   = (cur.op == OP_READ);
  assign has_ecc = (cur.op == OP_WDATA) || is_rd;
  assign active  = (state != S_IDLE);
  assign pop     = (state == S_IDLE) && !empty;
  assign idle    = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= '0;
      cnt     <= '0;
      rd_byte <= '0;
    end else begin
      case (state)
        S_IDLE: if (!empty) begin
          cur   <= head;
          cnt   <= (head.op == OP_READ) ? rd_dly : wr_dly;
          state <= S_STROBE;
        end
        S_STROBE: begin
          if (cnt == '0) begin
            if (is_rd) rd_byte <= fl_din;
            state <= S_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: if (!has_ecc || ecc_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign fl_we_n   = !((state == S_STROBE) && !is_rd);
  assign fl_re_n   = !((state == S_STROBE) && is_rd);
  assign fl_cle    = active && (cur.op == OP_CMD);
  assign fl_ale    = active && (cur.op == OP_ADDR);
  assign fl_doe    = active && !is_rd;
  assign fl_dout   = cur.byte_v;
  assign ecc_valid = (state == S_HOLD) && has_ecc;
  assign ecc_data  = is_rd ? rd_byte : cur.byte_v;
  assign rd_done   = (state == S_STROBE) && (cnt == '0) && is_rd;
  assign wr_done   = (state == S_HOLD) && (cur.op == OP_WDATA) && ecc_ready;
  assign wr_busy   = active && (cur.op == OP_WDATA);

  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_re_n) && !(fl_cle && fl_ale));
  // R10
  ecc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_valid && !ecc_ready) |=> (ecc_valid && $stable(ecc_data)));
  // R10
  ecc_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_valid && !ecc_ready) |=> (fl_we_n && fl_re_n));
endmodule

// File: rtl/nand_host_if.sv
module nand_host_if
  import nand_host_pkg::*;
#(
  parameter int DEPTH          = 4,
  parameter int ECC_RST_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_we_n,
  output logic              fl_re_n,
  output logic              fl_doe,
  output logic [BYTE_W-1:0] fl_dout,
  input  logic [BYTE_W-1:0] fl_din,
  input  logic              fl_rdy,
  output logic              ecc_valid,
  input  logic              ecc_ready,
  output logic [BYTE_W-1:0] ecc_data,
  output logic              ecc_clr
);
  localparam int OW = $clog2(DEPTH + 2) + 1;
  localparam int EW = (ECC_RST_CYCLES > 1) ? $clog2(ECC_RST_CYCLES) : 1;

  logic [9:0]       ctrl_q;
  logic [IST_W-1:0] istat_q, imask_q, ist_set, ist_clr;
  logic             push, full, empty, pop, accepted, overflow;
  wb_entry_t        push_entry, head;
  logic             rd_done, wr_done, seq_idle, wr_busy;
  logic [BYTE_W-1:0] rd_byte;
  logic [OW-1:0]    rd_pend;
  logic             rdy_q, drained, drained_q;
  logic             ecc_busy;
  logic [EW-1:0]    ecc_cnt;

  assign push             = reg_wr && (reg_addr[3:2] == 2'b01);
  assign push_entry.op    = op_e'(reg_addr[1:0]);
  assign push_entry.byte_v = reg_wdata[BYTE_W-1:0];
  assign accepted         = push && !full;
  assign overflow         = push && full;

  nand_wbuf #(.DEPTH(DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .push(push), .push_entry(push_entry),
    .pop(pop), .head(head), .full(full), .empty(empty)
  );

  nand_pin_seq u_seq (
    .clk(clk), .rst_n(rst_n), .head(head), .empty(empty), .pop(pop),
    .wr_dly(ctrl_q[3:0]), .rd_dly(ctrl_q[7:4]),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
    .fl_doe(fl_doe), .fl_dout(fl_dout), .fl_din(fl_din),
    .ecc_valid(ecc_valid), .ecc_ready(ecc_ready), .ecc_data(ecc_data),
    .rd_done(rd_done), .rd_byte(rd_byte), .wr_done(wr_done),
    .idle(seq_idle), .wr_busy(wr_busy)
  );

  assign drained = empty && seq_idle;

  always_comb begin
    ist_set = '0;
    ist_set[IB_NBUSY] = fl_rdy && !rdy_q;
    ist_set[IB_OVF]   = overflow;
    ist_set[IB_EDGE]  = drained && !drained_q;
    ist_set[IB_RDRDY] = rd_done;
    ist_set[IB_WDONE] = wr_done;
    ist_clr = (reg_wr && reg_addr == RA_ISTAT) ? reg_wdata[IST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      imask_q   <= '0;
      istat_q   <= '0;
      rdy_q     <= 1'b1;
      drained_q <= 1'b1;
      rd_pend   <= '0;
      ecc_busy  <= 1'b0;
      ecc_cnt   <= '0;
    end else begin
      rdy_q     <= fl_rdy;
      drained_q <= drained;
      istat_q   <= (istat_q & ~ist_clr) | ist_set;
      if (reg_wr && reg_addr == RA_CTRL)  ctrl_q  <= reg_wdata[9:0];
      if (reg_wr && reg_addr == RA_IMASK) imask_q <= reg_wdata[IST_W-1:0];
      case ({accepted && reg_addr == RA_RDREQ, rd_done})
        2'b10:   rd_pend <= rd_pend + 1'b1;
        2'b01:   rd_pend <= rd_pend - 1'b1;
        default: rd_pend <= rd_pend;
      endcase
      if (reg_wr && reg_addr == RA_ECCRST && reg_wdata[0] && !ecc_busy) begin
        ecc_busy <= 1'b1;
        ecc_cnt  <= EW'(ECC_RST_CYCLES - 1);
      end else if (ecc_busy) begin
        if (ecc_cnt == '0) ecc_busy <= 1'b0;
        else               ecc_cnt  <= ecc_cnt - 1'b1;
      end
    end
  end

  assign irq     = |(istat_q & imask_q);
  assign ecc_clr = ecc_busy;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:   reg_rdata[9:0] = ctrl_q;
      RA_STAT:   reg_rdata[4:0] = {drained, (rd_pend != '0), wr_busy, full, fl_rdy};
      RA_ISTAT:  reg_rdata[IST_W-1:0] = istat_q;
      RA_IMASK:  reg_rdata[IST_W-1:0] = imask_q;
      RA_RDDATA: reg_rdata[BYTE_W-1:0] = rd_byte;
      RA_ECCRST: reg_rdata[0] = ecc_busy;
      default:   reg_rdata = '0;
    endcase
  end

  // R4
  rd_ready_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> istat_q[IB_RDRDY]);
  // R8
  nbusy_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rdy && !rdy_q) |=> istat_q[IB_NBUSY]);
  // R9
  ecc_clr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_busy && ecc_cnt == '0) |=> !ecc_clr);
  // R6
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> istat_q[IB_OVF]);
endmodule

// File: tb/nand_host_if_bench.sv
module nand_host_if_bench;
  localparam int DEPTH = 4;
  localparam int ECYC  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_doe;
  logic [7:0]  fl_dout, fl_din, ecc_data;
  logic        fl_rdy = 1'b1;
  logic        ecc_valid, ecc_clr;
  logic        ecc_ready = 1'b1;
  logic [7:0]  rd_pat = 8'h00;

  always #5 clk = ~clk;
  assign fl_din = fl_re_n ? 8'h00 : rd_pat;

  nand_host_if #(.DEPTH(DEPTH), .ECC_RST_CYCLES(ECYC)) u_nand_host_if (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
    .fl_doe(fl_doe), .fl_dout(fl_dout), .fl_din(fl_din), .fl_rdy(fl_rdy),
    .ecc_valid(ecc_valid), .ecc_ready(ecc_ready), .ecc_data(ecc_data),
    .ecc_clr(ecc_clr)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [9:0] exp_wq[$];
  logic [7:0] exp_eq[$];
  int exp_wlen = 1, exp_rlen = 1;
  int excl_bad = 0;
  int ecc_clr_len = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // driver: scoreboard push then register write
  task automatic q_cycle(input logic [3:0] a, input logic [7:0] b);
    exp_wq.push_back({a == 4'h4, a == 4'h5, b});
    if (a == 4'h6) exp_eq.push_back(b);
    wr(a, {8'h00, b});
  endtask

  task automatic set_ctrl(input logic [15:0] v);
    exp_wlen = int'(v[3:0]) + 1;
    exp_rlen = int'(v[7:4]) + 1;
    wr(4'h0, v);
  endtask

  task automatic wait_drain();
    logic [15:0] s;
    for (int i = 0; i < 500; i++) begin
      rd(4'h1, s);
      if (s[4]) break;
    end
  endtask

  // monitor
  int  wlow = 0, rlow = 0;
  logic pwe = 1'b1, pre = 1'b1;
  logic [9:0] cap;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((!fl_we_n && !fl_re_n) || (fl_cle && fl_ale)) excl_bad++;
      if (!fl_we_n) begin wlow++; cap = {fl_cle, fl_ale, fl_dout}; end
      if (fl_we_n && !pwe) begin
        if (exp_wq.size() == 0) chk(0, "R2 unexpected write cycle", int'(cap), 0);
        else begin
          logic [9:0] e;
          e = exp_wq.pop_front();
          chk(cap == e, "R2 cycle type/byte", int'(cap), int'(e));
        end
        chk(wlow == exp_wlen, "R3 we_n width", wlow, exp_wlen);
        wlow = 0;
      end
      if (!fl_re_n) rlow++;
      if (fl_re_n && !pre) begin
        chk(rlow == exp_rlen, "R3 re_n width", rlow, exp_rlen);
        rlow = 0;
      end
      if (ecc_valid && ecc_ready) begin
        if (exp_eq.size() == 0) chk(0, "R10 unexpected ecc beat", int'(ecc_data), 0);
        else begin
          logic [7:0] e8;
          e8 = exp_eq.pop_front();
          chk(ecc_data == e8, "R10 ecc beat byte", int'(ecc_data), int'(e8));
        end
      end
      if (ecc_clr) ecc_clr_len++;
      pwe = fl_we_n; pre = fl_re_n;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int pushed;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(4'h1, v); chk(v == 16'h0011, "R7 reset status", v, 16'h0011);
    rd(4'h2, v); chk(v == 16'h0000, "R5 reset istat", v, 0);
    rd(4'h0, v); chk(v == 16'h0000, "R1 reset ctrl", v, 0);
    chk(irq == 1'b0, "R12 reset irq", irq, 0);

    set_ctrl(16'h0321);
    rd(4'h0, v); chk(v == 16'h0321, "R1 ctrl readback", v, 16'h0321);

    q_cycle(4'h4, 8'h80);
    q_cycle(4'h5, 8'h12);
    q_cycle(4'h5, 8'h34);
    q_cycle(4'h6, 8'hA5);
    q_cycle(4'h6, 8'h5A);
    wait_drain();
    rd(4'h2, v);
    chk(v[2] == 1'b1, "R11 drain edge flag", v[2], 1);
    chk(v[4] == 1'b1, "R11 write done flag", v[4], 1);
    chk(irq == 1'b0, "R12 masked irq low", irq, 0);
    wr(4'h3, 16'h0010);
    #1 chk(irq == 1'b1, "R12 unmasked irq high", irq, 1);
    wr(4'h2, 16'h0014);
    rd(4'h2, v); chk(v == 16'h0000, "R5 w1c clears", v, 0);
    chk(irq == 1'b0, "R12 irq after clear", irq, 0);

    set_ctrl(16'h0032);
    rd_pat = 8'hC3;
    exp_eq.push_back(8'hC3);
    wr(4'h7, 16'h0055);
    rd(4'h1, v); chk(v[3] == 1'b1, "R7 read pending", v[3], 1);
    for (int i = 0; i < 100; i++) begin
      rd(4'h2, v);
      if (v[3]) break;
    end
    chk(v[3] == 1'b1, "R4 read ready flag", v[3], 1);
    rd(4'h8, v); chk(v[7:0] == 8'hC3, "R4 read byte", v[7:0], 8'hC3);
    rd(4'h1, v); chk(v[3] == 1'b0, "R7 read pending cleared", v[3], 0);
    wr(4'h2, 16'h0008);
    rd(4'h2, v); chk(v[3] == 1'b0, "R5 ready flag cleared", v[3], 0);

    ecc_ready = 1'b0;
    q_cycle(4'h6, 8'h3C);
    q_cycle(4'h4, 8'h70);
    repeat (30) @(negedge clk);
    chk(exp_wq.size() == 1, "R10 stall holds next cycle", exp_wq.size(), 1);
    chk(ecc_valid == 1'b1, "R10 beat held valid", ecc_valid, 1);
    rd(4'h1, v); chk(v[4] == 1'b0, "R7 not drained while stalled", v[4], 0);
    chk(v[2] == 1'b1, "R7 write in flight", v[2], 1);
    @(negedge clk) ecc_ready = 1'b1;
    wait_drain();
    chk(exp_wq.size() == 0, "R10 resumed after accept", exp_wq.size(), 0);
    wr(4'h2, 16'h001F);

    set_ctrl(16'h000F);
    pushed = 0;
    for (int i = 0; i < 10; i++) begin
      rd(4'h1, v);
      if (v[1]) break;
      q_cycle(4'h5, 8'(8'h40 + i));
      pushed++;
    end
    chk(v[1] == 1'b1, "R6 full flag", v[1], 1);
    chk(pushed == DEPTH + 1, "R6 entries before full", pushed, DEPTH + 1);
    wr(4'h5, 16'h00EE);
    rd(4'h2, v); chk(v[1] == 1'b1, "R6 overflow flag", v[1], 1);
    wait_drain();
    chk(exp_wq.size() == 0, "R6 dropped entry not issued", exp_wq.size(), 0);
    wr(4'h2, 16'h001F);
    set_ctrl(16'h0000);

    fl_rdy = 1'b0;
    rd(4'h1, v); chk(v[0] == 1'b0, "R7 busy mirrored", v[0], 0);
    rd(4'h2, v); chk(v[0] == 1'b0, "R8 no event on fall", v[0], 0);
    fl_rdy = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'h2, v); chk(v[0] == 1'b1, "R8 ready rise event", v[0], 1);
    rd(4'h1, v); chk(v[0] == 1'b1, "R7 ready mirrored", v[0], 1);

    ecc_clr_len = 0;
    wr(4'h9, 16'h0001);
    rd(4'h9, v); chk(v[0] == 1'b1, "R9 reset bit reads 1", v[0], 1);
    repeat (ECYC + 3) @(negedge clk);
    rd(4'h9, v); chk(v[0] == 1'b0, "R9 reset bit self clears", v[0], 0);
    chk(ecc_clr_len == ECYC, "R9 ecc_clr length", ecc_clr_len, ECYC);

    chk(excl_bad == 0, "R13 strobe/latch exclusion", excl_bad, 0);
    chk(exp_eq.size() == 0, "R10 all ecc beats seen", exp_eq.size(), 0);
    finish_run();
  end
endmodule